// File: doc/BRIEF.md
# Controlled-Slip Elastic Store

This block sits between a byte stream timed by a clock recovered from the line and a local equipment clock. Each byte is written on the write clock. On the read side one byte is delivered on every local clock cycle. The two clocks are nominally equal but drift apart. The storage holds four blocks of eight bytes. The input stream marks the first byte of each block with a start strobe.

Rate mismatch is never absorbed one byte at a time. When the writer is running ahead and storage is about to overflow, the next incoming block is discarded whole. When the reader is running ahead and no fresh complete block is ready, the block most recently delivered is delivered again. Both decisions are taken only at a block boundary, on the side that performs the slip. The output therefore carries only whole blocks. Each slip restores a block's worth of margin, and normal flow continues without losing block alignment. Every slip is reported in the read domain as a one-cycle pulse of its own kind, and a saturating counter totals the slips.

Top module: `slip_elastic_store`

## Requirements
- R1: While either reset is held and after its release until data has been read, rd_valid, rd_sob, slip_del and slip_rep are low and slip_cnt is zero.
- R2: Reading starts once two complete blocks are stored. The first block delivered is the first complete block written. From then on rd_valid stays high on every read clock cycle.
- R3: Output is whole blocks. rd_sob is high on every eighth valid byte, starting with the first. The eight bytes of a block come from one input block in offset order. (The bench tags each byte with the block number in bits 7:3 and the offset in bits 2:0.)
- R4: Each delivered block is the successor of the previous one, a repeat of it, or the one after its successor (exactly one block skipped). Block numbers are taken modulo 32.
- R5: At an input start strobe, if three or more committed blocks are still unread, the whole incoming block is discarded and its first byte is not stored. Each discard yields one slip_del pulse, and every skipped output block is matched by one slip_del.
- R6: At the end of an output block, if no further complete block is stored, the same block is delivered again and slip_rep pulses once, one cycle before that repeat's rd_sob. Every repeat is matched by one slip_rep.
- R7: slip_del and slip_rep are single-cycle pulses. slip_cnt changes only in a cycle with a pulse, rises by one per pulse, and holds at all ones once it gets there.
- R8: With the clocks about 1% apart, at least 20 output blocks pass between any two slips.
- R9: Bytes that arrive before any start strobe are ignored. A start strobe in the middle of a block abandons the partial block.
- R10: The writer never stores into the slot being read or kept for a repeat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Recovered write clock |
| wrst_n | input | 1 | Write-domain asynchronous reset, active low |
| wr_valid | input | 1 | A byte is presented this write cycle |
| wr_sob | input | 1 | The presented byte is the first of a block |
| wr_data | input | 8 | Input byte |
| rclk | input | 1 | Local read clock |
| rrst_n | input | 1 | Read-domain asynchronous reset, active low |
| rd_valid | output | 1 | Output byte is valid |
| rd_sob | output | 1 | Output byte is the first of a block |
| rd_data | output | 8 | Output byte |
| slip_del | output | 1 | One-cycle pulse: an input block was discarded |
| slip_rep | output | 1 | One-cycle pulse: an output block is being repeated |
| slip_cnt | output | 16 | Saturating count of all slips |

## Verification
The stimulus starts with junk bytes that carry no strobe and a partial block cut short by a new strobe. These show whether unanchored or abandoned bytes leak into the output. Next, the write clock runs about 1% fast, which can only produce skipped blocks and slip_del pulses. It then runs about 1% slow, which can only produce repeated blocks and slip_rep pulses. Last, it runs at the read rate with random idle gaps from a seeded generator, which tests repeat decisions under irregular arrival. Every block's number step and every byte's offset are compared with what R3 and R4 allow, and skip and repeat counts are matched against the pulses and the counter.

// File: rtl/es_pkg.sv
package es_pkg;
  localparam int ES_DW    = 8;
  localparam int ES_BLEN  = 8;
  localparam int ES_NBLK  = 4;
  localparam int ES_CW    = 16;
  localparam int ES_OW    = $clog2(ES_BLEN);
  localparam int ES_SW    = $clog2(ES_NBLK);
  localparam int ES_PW    = ES_SW + 1;
  localparam int ES_AW    = ES_SW + ES_OW;
  localparam int ES_DEPTH = ES_NBLK * ES_BLEN;

  typedef logic [ES_OW-1:0] ofs_t;
  typedef logic [ES_SW-1:0] slot_t;
  typedef logic [ES_PW-1:0] blkptr_t;
  typedef logic [ES_AW-1:0] addr_t;
  typedef logic [ES_CW-1:0] cnt_t;

  function automatic blkptr_t gray_enc(blkptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic blkptr_t gray_dec(blkptr_t g);
    blkptr_t b;
    b[ES_PW-1] = g[ES_PW-1];
    for (int i = ES_PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // blocks between two wrapping block pointers
  function automatic blkptr_t blk_dist(blkptr_t ahead, blkptr_t behind);
    return ahead - behind;
  endfunction

  function automatic slot_t slot_of(blkptr_t p);
    return p[ES_SW-1:0];
  endfunction

  function automatic cnt_t sat_add(cnt_t c, logic [1:0] n);
    logic [ES_CW:0] s;
    s = {1'b0, c} + {{(ES_CW-1){1'b0}}, n};
    return s[ES_CW] ? '1 : s[ES_CW-1:0];
  endfunction
endpackage

// File: rtl/es_sync.sv
module es_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/es_ram.sv
module es_ram
  import es_pkg::*;
(
  input  logic             wclk,
  input  logic             we,
  input  addr_t            waddr,
  input  logic [ES_DW-1:0] wdata,
  input  addr_t            raddr,
  output logic [ES_DW-1:0] rdata
);
  logic [ES_DW-1:0] mem [ES_DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/es_wr_ctrl.sv
module es_wr_ctrl
  import es_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr_valid,
  input  logic    wr_sob,
  input  blkptr_t rsync,
  output logic    we,
  output addr_t   waddr,
  output blkptr_t blk,
  output blkptr_t blk_g,
  output logic    del_tog,
  output logic    drop_evt
);
  logic inblk, drop, room_low;
  ofs_t wofs;

  // committed-but-unread blocks leave no slot for a new one
  assign room_low = blk_dist(blk, rsync) >= blkptr_t'(ES_NBLK - 1);
  assign drop_evt = wr_valid && wr_sob && room_low;
  assign we       = wr_valid && (wr_sob ? !room_low : (inblk && !drop));
  assign waddr    = {slot_of(blk), (wr_sob ? ofs_t'(0) : wofs)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk     <= '0;
      blk_g   <= '0;
      wofs    <= '0;
      inblk   <= 1'b0;
      drop    <= 1'b0;
      del_tog <= 1'b0;
    end else if (wr_valid) begin
      if (wr_sob) begin
        inblk <= 1'b1;
        wofs  <= ofs_t'(1);
        drop  <= room_low;
        if (room_low) del_tog <= ~del_tog;
      end else if (inblk) begin
        wofs <= wofs + ofs_t'(1);
        if (wofs == ofs_t'(ES_BLEN - 1)) begin
          inblk <= 1'b0;
          if (!drop) begin
            blk   <= blk + blkptr_t'(1);
            blk_g <= gray_enc(blk + blkptr_t'(1));
          end
        end
      end
    end
  end
endmodule

// File: rtl/es_rd_ctrl.sv
module es_rd_ctrl
  import es_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  blkptr_t          wsync,
  output addr_t            raddr,
  input  logic [ES_DW-1:0] rdata,
  output logic             rd_valid,
  output logic             rd_sob,
  output logic [ES_DW-1:0] rd_data,
  output blkptr_t          rptr_g,
  output logic             rep_evt
);
  logic    run, start, at_bound, take;
  ofs_t    rofs;
  blkptr_t cur, rptr, rptr_nx, avail;

  assign avail    = blk_dist(wsync, rptr);
  assign start    = !run && (avail >= blkptr_t'(ES_NBLK / 2));
  assign at_bound = run && (rofs == ofs_t'(ES_BLEN - 1));
  assign take     = at_bound && (avail != '0);
  assign rep_evt  = at_bound && (avail == '0);
  assign rptr_nx  = (start || take) ? rptr + blkptr_t'(1) : rptr;
  assign raddr    = {slot_of(cur), rofs};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      rofs     <= '0;
      cur      <= '0;
      rptr     <= '0;
      rptr_g   <= '0;
      rd_valid <= 1'b0;
      rd_sob   <= 1'b0;
      rd_data  <= '0;
    end else begin
      rptr   <= rptr_nx;
      rptr_g <= gray_enc(rptr_nx);
      if (start) begin
        run  <= 1'b1;
        rofs <= '0;
        cur  <= rptr;
      end else if (run) begin
        rofs <= rofs + ofs_t'(1);
        if (take) cur <= rptr;
      end
      rd_valid <= run;
      rd_sob   <= run && (rofs == '0);
      rd_data  <= rdata;
    end
  end
endmodule

// File: rtl/slip_elastic_store.sv
module slip_elastic_store
  import es_pkg::*;
(
  input  logic             wclk,
  input  logic             wrst_n,
  input  logic             wr_valid,
  input  logic             wr_sob,
  input  logic [ES_DW-1:0] wr_data,
  input  logic             rclk,
  input  logic             rrst_n,
  output logic             rd_valid,
  output logic             rd_sob,
  output logic [ES_DW-1:0] rd_data,
  output logic             slip_del,
  output logic             slip_rep,
  output logic [ES_CW-1:0] slip_cnt
);
  logic             w_we, w_del_tog, w_drop_evt;
  addr_t            w_addr, r_addr;
  blkptr_t          w_blk, w_blk_g, w_rsync_g, w_rsync;
  blkptr_t          r_wsync_g, r_wsync, r_rptr_g;
  logic [ES_DW-1:0] r_rdata;
  logic             r_rep_evt, r_del_s, r_del_q, r_del_evt;

  es_sync #(.W(ES_PW)) u_r2w (
    .clk(wclk), .rst_n(wrst_n), .d(r_rptr_g), .q(w_rsync_g)
  );
  assign w_rsync = gray_dec(w_rsync_g);

  es_wr_ctrl u_wr (
    .clk(wclk), .rst_n(wrst_n), .wr_valid(wr_valid), .wr_sob(wr_sob),
    .rsync(w_rsync), .we(w_we), .waddr(w_addr), .blk(w_blk),
    .blk_g(w_blk_g), .del_tog(w_del_tog), .drop_evt(w_drop_evt)
  );

  es_ram u_ram (
    .wclk(wclk), .we(w_we), .waddr(w_addr), .wdata(wr_data),
    .raddr(r_addr), .rdata(r_rdata)
  );

  es_sync #(.W(ES_PW)) u_w2r (
    .clk(rclk), .rst_n(rrst_n), .d(w_blk_g), .q(r_wsync_g)
  );
  assign r_wsync = gray_dec(r_wsync_g);

  es_sync #(.W(1)) u_del (
    .clk(rclk), .rst_n(rrst_n), .d(w_del_tog), .q(r_del_s)
  );
  assign r_del_evt = r_del_s ^ r_del_q;

  es_rd_ctrl u_rd (
    .clk(rclk), .rst_n(rrst_n), .wsync(r_wsync), .raddr(r_addr),
    .rdata(r_rdata), .rd_valid(rd_valid), .rd_sob(rd_sob),
    .rd_data(rd_data), .rptr_g(r_rptr_g), .rep_evt(r_rep_evt)
  );

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      r_del_q  <= 1'b0;
      slip_del <= 1'b0;
      slip_rep <= 1'b0;
      slip_cnt <= '0;
    end else begin
      r_del_q  <= r_del_s;
      slip_del <= r_del_evt;
      slip_rep <= r_rep_evt;
      slip_cnt <= sat_add(slip_cnt, {1'b0, r_del_evt} + {1'b0, r_rep_evt});
    end
  end
endmodule

// File: rtl/slip_elastic_store_chk.sv
module slip_elastic_store_chk
  import es_pkg::*;
(
  input logic    wclk,
  input logic    wrst_n,
  input logic    rclk,
  input logic    rrst_n,
  input logic    rd_valid,
  input logic    rd_sob,
  input logic    slip_del,
  input logic    slip_rep,
  input cnt_t    slip_cnt,
  input logic    w_we,
  input logic    w_drop_evt,
  input blkptr_t w_blk,
  input blkptr_t w_rsync
);
  ofs_t    pos;
  blkptr_t w_gap;

  assign w_gap = blk_dist(w_blk, w_rsync);

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) pos <= '0;
    else if (rd_valid) pos <= pos + ofs_t'(1);
  end

  // R3
  sob_cadence_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    rd_valid |-> (rd_sob == (pos == '0)));

  // R2
  stream_gapless_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    rd_valid |=> rd_valid);

  // R7
  del_pulse_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    slip_del |=> !slip_del);

  // R7
  rep_pulse_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    slip_rep |=> !slip_rep);

  // R7
  cnt_hold_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    (slip_cnt != $past(slip_cnt)) |-> (slip_del || slip_rep));

  // R7
  cnt_step_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    ((slip_del || slip_rep) && ($past(slip_cnt) != '1)) |-> (slip_cnt != $past(slip_cnt)));

  // R5
  drop_nowrite_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    w_drop_evt |-> !w_we);

  // R10
  no_overwrite_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    w_we |-> (w_gap <= blkptr_t'(ES_NBLK - 2)));
endmodule

bind slip_elastic_store slip_elastic_store_chk u_chk (
  .wclk(wclk), .wrst_n(wrst_n), .rclk(rclk), .rrst_n(rrst_n),
  .rd_valid(rd_valid), .rd_sob(rd_sob), .slip_del(slip_del),
  .slip_rep(slip_rep), .slip_cnt(slip_cnt), .w_we(w_we),
  .w_drop_evt(w_drop_evt), .w_blk(w_blk), .w_rsync(w_rsync)
);

// File: tb/slip_elastic_store_tb.sv
`timescale 1ns/1ps
module slip_elastic_store_tb;
  logic        wclk = 1'b0, rclk = 1'b0;
  logic        wrst_n = 1'b0, rrst_n = 1'b0;
  logic        wr_valid = 1'b0, wr_sob = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        rd_valid, rd_sob, slip_del, slip_rep;
  logic [7:0]  rd_data;
  logic [15:0] slip_cnt;

  real whalf = 1.98;

  int n_chk = 0, n_fail = 0;
  int wblocks = 0;
  int dels = 0, reps = 0, misses = 0, dups = 0;
  int pos = 0, blocks_since = 0;
  int reps_p2 = 0;
  bit started = 0, have_prev = 0, seen_slip = 0, gap_on = 1;
  logic [4:0] prev_id = 5'd0, cur_id = 5'd0;

  slip_elastic_store u_dut (
    .wclk(wclk), .wrst_n(wrst_n), .wr_valid(wr_valid), .wr_sob(wr_sob),
    .wr_data(wr_data), .rclk(rclk), .rrst_n(rrst_n), .rd_valid(rd_valid),
    .rd_sob(rd_sob), .rd_data(rd_data), .slip_del(slip_del),
    .slip_rep(slip_rep), .slip_cnt(slip_cnt)
  );

  always #2.0 rclk = ~rclk;
  always #(whalf) wclk = ~wclk;

  function automatic logic [4:0] blk_id(input logic [7:0] b);
    return b[7:3];
  endfunction

  function automatic logic [4:0] id_step(input logic [4:0] prev, input logic [4:0] now);
    return now - prev;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  task automatic put(input logic v, input logic s, input logic [7:0] d);
    @(negedge wclk);
    wr_valid = v;
    wr_sob   = s;
    wr_data  = d;
  endtask

  task automatic send_block(input int id, input int idle_mod);
    for (int k = 0; k < 8; k++) begin
      if (idle_mod > 0)
        while (($urandom % idle_mod) == 0) put(1'b0, 1'b0, 8'h00);
      put(1'b1, k == 0, {id[4:0], 3'(k)});
    end
    wblocks++;
  endtask

  // read-side monitor
  always @(negedge rclk) begin
    if (rrst_n) begin
      if (slip_del) dels++;
      if (slip_rep) reps++;
      if (slip_del || slip_rep) begin
        if (gap_on && seen_slip)
          chk(blocks_since >= 20, "R8 blocks between slips", blocks_since, 20);
        seen_slip = 1;
        blocks_since = 0;
      end
      if (rd_valid) begin
        if (!started) begin
          started = 1;
          chk(wblocks >= 2 && wblocks <= 3, "R2 blocks stored at start", wblocks, 2);
          chk(blk_id(rd_data) == 5'd0, "R9 first block number", blk_id(rd_data), 0);
        end
        if (rd_sob) begin
          if (have_prev) begin
            logic [4:0] st;
            st = id_step(prev_id, blk_id(rd_data));
            chk(st <= 5'd2, "R4 block step", st, 1);
            if (st == 5'd0) dups++;
            if (st == 5'd2) misses++;
          end
          prev_id = blk_id(rd_data);
          cur_id  = blk_id(rd_data);
          have_prev = 1;
          pos = 0;
          blocks_since++;
          chk(reps == dups, "R6 repeats vs slip_rep", dups, reps);
          chk(dels == misses || dels == misses + 1, "R5 skips vs slip_del", misses, dels);
          chk(slip_cnt == 16'(dels + reps), "R7 slip_cnt", slip_cnt, dels + reps);
        end
        chk(rd_sob == (pos == 0) && rd_data[2:0] == 3'(pos) && blk_id(rd_data) == cur_id,
            "R3 byte order", rd_data, {cur_id, 3'(pos)});
        pos = (pos + 1) % 8;
      end
    end
  end

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(negedge rclk);
    // R1 during reset
    chk(!rd_valid && !rd_sob, "R1 output idle in reset", rd_valid, 0);
    chk(!slip_del && !slip_rep, "R1 pulses idle in reset", slip_del | slip_rep, 0);
    chk(slip_cnt == 16'd0, "R1 counter in reset", slip_cnt, 0);
    wrst_n = 1'b1;
    rrst_n = 1'b1;
    // R9 junk without a strobe, then a partial block cut short
    for (int k = 0; k < 5; k++) put(1'b1, 1'b0, 8'hFF);
    for (int k = 0; k < 3; k++) put(1'b1, k == 0, {5'd17, 3'(k)});
    repeat (3) @(negedge rclk);
    chk(!rd_valid && slip_cnt == 16'd0, "R1 idle after release", rd_valid, 0);
    // phase 1: writer about 1% fast
    whalf = 1.98;
    for (int b = 0; b < 1200; b++) send_block(b, 0);
    // phase 2: writer about 1% slow
    whalf = 2.02;
    for (int b = 1200; b < 1210; b++) send_block(b, 0);
    chk(dels > 0, "R5 deletes with fast writer", dels, 1);
    chk(misses == dels, "R5 skips equal slip_del", misses, dels);
    chk(reps == 0, "R6 no repeat while fast", reps, 0);
    for (int b = 1210; b < 2700; b++) send_block(b, 0);
    chk(reps > 0, "R6 repeats with slow writer", reps, 1);
    chk(dels == misses, "R5 no delete while slow", dels, misses);
    reps_p2 = reps;
    // phase 3: matched clocks, random idle gaps
    whalf = 2.0;
    for (int b = 2700; b < 3700; b++) send_block(b, 100);
    gap_on = 0;
    put(1'b0, 1'b0, 8'h00);
    repeat (60) @(negedge rclk);
    chk(reps > reps_p2, "R6 repeats under idle gaps", reps, reps_p2 + 1);
    chk(misses == dels, "R5 final skips", misses, dels);
    chk(slip_cnt == 16'(dels + reps), "R7 final slip_cnt", slip_cnt, dels + reps);
    summary();
    $finish;
  end
endmodule